// File: doc/BRIEF.md
# Deferred-Exception Poison Tracker for Speculative Loads

This block sits beside the integer and floating-point register files and records, for every register, whether its contents are the product of a speculative load that faulted. A speculative load that would trap does not raise anything at the time it runs. Instead its destination is marked as poisoned. In the integer file this marker is a tag bit. In the floating-point file it is a reserved marker value stored in the register. Any result computed from a poisoned source is itself written as poisoned, so the mark follows the dependence chain.

A later check on a named register turns a poisoned state into a deferred exception. That check produces a failure result and a one-cycle recovery pulse that carries the recovery address supplied with the check. There are two kinds of check. The plain tag check looks only at the poison mark. The advanced check also fails when an external address-conflict flag is raised, which serves loads that are speculative on both control and data. Load execution, address-conflict detection and trap delivery are all outside this block.

The write port commits one write per cycle and never back-pressures: `wr_ready` is always high. Check requests enter on a valid/ready port and results leave on a valid/ready port. A check is accepted only when the result slot is empty or is being drained in that same cycle. A result that is not taken stays unchanged until `res_ready` rises.

Top module: `spt_tag_file`

## Requirements
- R1: After reset, every register in both files reads as 0 and not poisoned, `res_valid` and `rec_pulse` are 0, and `chk_ready` is 1.
- R2: A write with `wr_op`=0 (plain) stores `wr_data` and leaves the register not poisoned. In particular, it clears an integer tag that was set before.
- R3: A write with `wr_op`=1 (speculative load) and `wr_fault`=1 poisons its destination. An integer register then reads data 0 with tag 1. A floating-point register then holds the marker value 64'h7FF4_0000_0000_0001 and reports tag 1. With `wr_fault`=0 the write behaves like a plain write.
- R4: A write with `wr_op`=2 (dependent operation) reads the poison state of `wr_src_a` and `wr_src_b` in the same file as the destination. If either source is poisoned, the result is poisoned (integer: data 0, tag 1; floating point: the marker value). Otherwise `wr_data` is stored clean.
- R5: A write with `wr_op`=3 (combined control-and-data speculative load) has the same effect on the register as `wr_op`=1.
- R6: Register 0 of each file always reads data 0 and not poisoned. Writes to it have no effect. As a source of a dependent operation it counts as clean.
- R7: A check with `chk_kind`=0 (tag check) fails exactly when the named register (`chk_file` 0 = integer, 1 = floating point) is poisoned. For this kind, `chk_conflict` is ignored.
- R8: A check with `chk_kind`=1 (advanced check) fails when the named register is poisoned or when `chk_conflict` is 1.
- R9: In the cycle after a check is accepted, `res_valid` is 1 and `res_fail` gives the outcome. On a failure, `rec_pulse` is high for that one cycle and `rec_addr` equals the `chk_target` given with the check. A passing check gives no pulse.
- R10: `chk_ready` equals `!res_valid || res_ready`. While `res_valid` is 1 and `res_ready` is 0, the result stays valid and `res_fail` stays unchanged.
- R11: A check accepted in the same cycle as a write to the same register sees the poison state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_file | input | 1 | Destination file: 0 integer, 1 floating point |
| wr_op | input | 2 | 0 plain, 1 speculative load, 2 dependent op, 3 combined speculative load |
| wr_idx | input | 5 | Destination register |
| wr_src_a | input | 5 | First source register for dependent ops |
| wr_src_b | input | 5 | Second source register for dependent ops |
| wr_fault | input | 1 | The speculative load hit an exception condition |
| wr_data | input | 64 | Write data |
| rd_file | input | 2 | File select, one bit per read port |
| rd_idx | input | 10 | Register index, 5 bits per read port |
| rd_data | output | 128 | Read data, 64 bits per read port |
| rd_tag | output | 2 | Poisoned flag, one bit per read port |
| chk_valid | input | 1 | Check request valid |
| chk_ready | output | 1 | Check request accepted |
| chk_file | input | 1 | File of the checked register |
| chk_kind | input | 1 | 0 tag check, 1 advanced check |
| chk_idx | input | 5 | Checked register |
| chk_conflict | input | 1 | External address-conflict flag for advanced checks |
| chk_target | input | 48 | Recovery address |
| res_valid | output | 1 | Check result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_fail | output | 1 | The check failed (deferred exception) |
| rec_pulse | output | 1 | One-cycle recovery request |
| rec_addr | output | 48 | Recovery address of the last failing check |

## Verification
The assertions check four things on every clock. Writes to a non-zero register land in the addressed entry of the right bank. Register 0 reads back clean on every read port. An accepted failing check is followed by a recovery pulse with the matching address, and no pulse appears without an accepted check. A result that is back-pressured stays valid and stable. The bench scenarios are needed for the rest. They show the poison moving from faulting loads through dependent operations in both files, and a plain write clearing a mark. They show how the two check kinds treat the conflict flag differently, and that a check issued in the same cycle as a write sees the state from before that write.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN    = 2'd0,
    OP_SPEC     = 2'd1,
    OP_DEP      = 2'd2,
    OP_SPEC_ADV = 2'd3
  } wr_op_e;

  typedef enum logic {
    FILE_INT = 1'b0,
    FILE_FP  = 1'b1
  } file_e;

  typedef enum logic {
    CHK_TAG = 1'b0,
    CHK_ADV = 1'b1
  } chk_kind_e;
endpackage

// File: rtl/spt_int_bank.sv
// Integer bank: data word plus an explicit poison bit per register.
module spt_int_bank #(
  parameter int NREG = 32,
  parameter int DW   = 64,
  parameter int NRP  = 5,
  parameter int IW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DW-1:0]     wdata,
  input  logic              wtag,
  input  logic [NRP*IW-1:0] ridx,
  output logic [NRP*DW-1:0] rdata,
  output logic [NRP-1:0]    rtag
);
  logic [DW-1:0] data_q [NREG];
  logic [NREG-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) data_q[r] <= '0;
      tag_q <= '0;
    end else if (we && widx != '0) begin
      data_q[widx] <= wdata;
      tag_q[widx]  <= wtag;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_port
    logic [IW-1:0] ix;
    assign ix = ridx[p*IW +: IW];
    // register 0 is hard-wired clean
    assign rdata[p*DW +: DW] = (ix == '0) ? '0 : data_q[ix];
    assign rtag[p]           = (ix == '0) ? 1'b0 : tag_q[ix];
  end

  AST_INT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx != '0) |=> (data_q[$past(widx)] == $past(wdata) && tag_q[$past(widx)] == $past(wtag)))
    else $error("int write lost"); // R2
endmodule

// File: rtl/spt_fp_bank.sv
// Floating-point bank: poison is a reserved marker value in the register itself.
module spt_fp_bank #(
  parameter int          NREG = 32,
  parameter int          DW   = 64,
  parameter int          NRP  = 5,
  parameter logic [63:0] MARK = 64'h7FF4_0000_0000_0001,
  parameter int          IW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DW-1:0]     wdata,
  input  logic [NRP*IW-1:0] ridx,
  output logic [NRP*DW-1:0] rdata,
  output logic [NRP-1:0]    rpois
);
  localparam logic [DW-1:0] MARK_W = MARK[DW-1:0];

  logic [DW-1:0] data_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) data_q[r] <= '0;
    end else if (we && widx != '0) begin
      data_q[widx] <= wdata;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_port
    logic [IW-1:0] ix;
    logic [DW-1:0] val;
    assign ix    = ridx[p*IW +: IW];
    assign val   = (ix == '0) ? '0 : data_q[ix];
    assign rdata[p*DW +: DW] = val;
    assign rpois[p] = (val == MARK_W);
  end

  AST_FP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx != '0) |=> (data_q[$past(widx)] == $past(wdata)))
    else $error("fp write lost"); // R2
endmodule

// File: rtl/spt_write_shaper.sv
// Turns a write request into the value/tag actually stored, per op kind.
module spt_write_shaper
  import spt_pkg::*;
#(
  parameter int          DW   = 64,
  parameter logic [63:0] MARK = 64'h7FF4_0000_0000_0001
) (
  input  logic [1:0]    op,
  input  logic          fault,
  input  logic [DW-1:0] data,
  input  logic          src_a_pois,
  input  logic          src_b_pois,
  output logic          pois,
  output logic [DW-1:0] int_wdata,
  output logic [DW-1:0] fp_wdata
);
  always_comb begin
    unique case (wr_op_e'(op))
      OP_PLAIN:    pois = 1'b0;
      OP_SPEC:     pois = fault;
      OP_SPEC_ADV: pois = fault;
      OP_DEP:      pois = src_a_pois | src_b_pois;
      default:     pois = 1'b0;
    endcase
    int_wdata = pois ? '0 : data;
    fp_wdata  = pois ? MARK[DW-1:0] : data;
  end
endmodule

// File: rtl/spt_check_unit.sv
// Evaluates speculation checks and holds the result on a valid/ready output.
module spt_check_unit
  import spt_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_valid,
  output logic          chk_ready,
  input  logic          chk_kind,
  input  logic          chk_conflict,
  input  logic [AW-1:0] chk_target,
  input  logic          poisoned,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_fail,
  output logic          rec_pulse,
  output logic [AW-1:0] rec_addr
);
  logic accept;
  logic fail_now;

  assign chk_ready = !res_valid || res_ready;
  assign accept    = chk_valid && chk_ready;
  assign fail_now  = poisoned || (chk_kind == CHK_ADV && chk_conflict);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
      rec_pulse <= 1'b0;
      rec_addr  <= '0;
    end else begin
      rec_pulse <= accept && fail_now;
      if (accept) begin
        res_valid <= 1'b1;
        res_fail  <= fail_now;
        if (fail_now) rec_addr <= chk_target;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  AST_FAIL_RAISES_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_ready && fail_now) |=> (rec_pulse && rec_addr == $past(chk_target)))
    else $error("failing check without recovery"); // R9
  AST_REC_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_pulse |-> $past(chk_valid && chk_ready))
    else $error("spurious recovery pulse"); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fail)))
    else $error("result dropped under back-pressure"); // R10
endmodule

// File: rtl/spt_tag_file.sv
module spt_tag_file
  import spt_pkg::*;
#(
  parameter int          NREG   = 32,
  parameter int          DW     = 64,
  parameter int          AW     = 48,
  parameter int          NUM_RD = 2,
  parameter logic [63:0] FP_MARK = 64'h7FF4_0000_0000_0001,
  parameter int          IW     = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic                 wr_file,
  input  logic [1:0]           wr_op,
  input  logic [IW-1:0]        wr_idx,
  input  logic [IW-1:0]        wr_src_a,
  input  logic [IW-1:0]        wr_src_b,
  input  logic                 wr_fault,
  input  logic [DW-1:0]        wr_data,
  input  logic [NUM_RD-1:0]    rd_file,
  input  logic [NUM_RD*IW-1:0] rd_idx,
  output logic [NUM_RD*DW-1:0] rd_data,
  output logic [NUM_RD-1:0]    rd_tag,
  input  logic                 chk_valid,
  output logic                 chk_ready,
  input  logic                 chk_file,
  input  logic                 chk_kind,
  input  logic [IW-1:0]        chk_idx,
  input  logic                 chk_conflict,
  input  logic [AW-1:0]        chk_target,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_fail,
  output logic                 rec_pulse,
  output logic [AW-1:0]        rec_addr
);
  // lookup ports: external reads, then source A, source B, check
  localparam int NRP   = NUM_RD + 3;
  localparam int P_SRA = NUM_RD;
  localparam int P_SRB = NUM_RD + 1;
  localparam int P_CHK = NUM_RD + 2;

  logic [NRP*IW-1:0] bank_ridx;
  logic [NRP*DW-1:0] int_rdata, fp_rdata;
  logic [NRP-1:0]    int_tag, fp_pois;
  logic              src_a_pois, src_b_pois, chk_pois;
  logic              w_pois;
  logic [DW-1:0]     int_wdata, fp_wdata;
  logic              int_we, fp_we;

  assign wr_ready  = 1'b1;
  assign bank_ridx = {chk_idx, wr_src_b, wr_src_a, rd_idx};

  assign src_a_pois = (wr_file == FILE_FP) ? fp_pois[P_SRA] : int_tag[P_SRA];
  assign src_b_pois = (wr_file == FILE_FP) ? fp_pois[P_SRB] : int_tag[P_SRB];
  assign chk_pois   = (chk_file == FILE_FP) ? fp_pois[P_CHK] : int_tag[P_CHK];

  assign int_we = wr_valid && (wr_file == FILE_INT);
  assign fp_we  = wr_valid && (wr_file == FILE_FP);

  spt_write_shaper #(.DW(DW), .MARK(FP_MARK)) u_shaper (
    .op         (wr_op),
    .fault      (wr_fault),
    .data       (wr_data),
    .src_a_pois (src_a_pois),
    .src_b_pois (src_b_pois),
    .pois       (w_pois),
    .int_wdata  (int_wdata),
    .fp_wdata   (fp_wdata)
  );

  spt_int_bank #(.NREG(NREG), .DW(DW), .NRP(NRP), .IW(IW)) u_int (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (int_we),
    .widx  (wr_idx),
    .wdata (int_wdata),
    .wtag  (w_pois),
    .ridx  (bank_ridx),
    .rdata (int_rdata),
    .rtag  (int_tag)
  );

  spt_fp_bank #(.NREG(NREG), .DW(DW), .NRP(NRP), .MARK(FP_MARK), .IW(IW)) u_fp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fp_we),
    .widx  (wr_idx),
    .wdata (fp_wdata),
    .ridx  (bank_ridx),
    .rdata (fp_rdata),
    .rpois (fp_pois)
  );

  spt_check_unit #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .chk_ready    (chk_ready),
    .chk_kind     (chk_kind),
    .chk_conflict (chk_conflict),
    .chk_target   (chk_target),
    .poisoned     (chk_pois),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_fail     (res_fail),
    .rec_pulse    (rec_pulse),
    .rec_addr     (rec_addr)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [IW-1:0] ix;
    assign ix = rd_idx[p*IW +: IW];
    assign rd_data[p*DW +: DW] = rd_file[p] ? fp_rdata[p*DW +: DW] : int_rdata[p*DW +: DW];
    assign rd_tag[p]           = rd_file[p] ? fp_pois[p] : int_tag[p];

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (ix == '0) |-> (rd_data[p*DW +: DW] == '0 && !rd_tag[p]))
      else $error("register 0 not clean"); // R6
  end
endmodule

// File: tb/spt_tag_file_bench.sv
`timescale 1ns/1ps
module spt_tag_file_bench;
  localparam int NREG = 32;
  localparam int DW = 64;
  localparam int AW = 48;
  localparam int NUM_RD = 2;
  localparam int IW = 5;
  localparam logic [63:0] MARK = 64'h7FF4_0000_0000_0001;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_ready, wr_file, wr_fault;
  logic [1:0] wr_op;
  logic [IW-1:0] wr_idx, wr_src_a, wr_src_b;
  logic [DW-1:0] wr_data;
  logic [NUM_RD-1:0] rd_file;
  logic [NUM_RD*IW-1:0] rd_idx;
  logic [NUM_RD*DW-1:0] rd_data;
  logic [NUM_RD-1:0] rd_tag;
  logic chk_valid, chk_ready, chk_file, chk_kind, chk_conflict;
  logic [IW-1:0] chk_idx;
  logic [AW-1:0] chk_target;
  logic res_valid, res_ready, res_fail, rec_pulse;
  logic [AW-1:0] rec_addr;

  always #2 clk = ~clk;

  spt_tag_file u_spt_tag_file (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_file(wr_file), .wr_op(wr_op),
    .wr_idx(wr_idx), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_fault(wr_fault),
    .wr_data(wr_data), .rd_file(rd_file), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_tag(rd_tag), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_file(chk_file), .chk_kind(chk_kind), .chk_idx(chk_idx),
    .chk_conflict(chk_conflict), .chk_target(chk_target), .res_valid(res_valid),
    .res_ready(res_ready), .res_fail(res_fail), .rec_pulse(rec_pulse),
    .rec_addr(rec_addr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model of register state
  logic [DW-1:0] int_dat_m [NREG];
  bit            int_tag_m [NREG];
  logic [DW-1:0] fp_dat_m  [NREG];

  // scoreboard queues
  bit            exp_fail_q [$];
  logic [AW-1:0] exp_addr_q [$];
  int            exp_req_q  [$];

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit m_pois(bit f, int idx);
    if (idx == 0) return 1'b0;
    return f ? (fp_dat_m[idx] == MARK) : int_tag_m[idx];
  endfunction

  function automatic void m_write(bit f, int op, int idx, int sa, int sb, bit flt, logic [63:0] d);
    bit p;
    case (op)
      0: p = 1'b0;
      1, 3: p = flt;
      default: p = m_pois(f, sa) || m_pois(f, sb);
    endcase
    if (idx == 0) return;
    if (f) fp_dat_m[idx] = p ? MARK : d;
    else begin
      int_dat_m[idx] = p ? 64'h0 : d;
      int_tag_m[idx] = p;
    end
  endfunction

  task automatic wr(bit f, int op, int idx, int sa, int sb, bit flt, logic [63:0] d);
    @(negedge clk);
    wr_file = f; wr_op = op[1:0]; wr_idx = idx[IW-1:0];
    wr_src_a = sa[IW-1:0]; wr_src_b = sb[IW-1:0]; wr_fault = flt; wr_data = d;
    wr_valid = 1'b1;
    m_write(f, op, idx, sa, sb, flt, d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rdchk(string req, int port, bit f, int idx);
    @(negedge clk);
    rd_file[port] = f;
    rd_idx[port*IW +: IW] = idx[IW-1:0];
    #1;
    cmp(req, rd_data[port*DW +: DW], (idx == 0) ? 64'h0 : (f ? fp_dat_m[idx] : int_dat_m[idx]));
    cmp(req, {63'h0, rd_tag[port]}, {63'h0, m_pois(f, idx)});
  endtask

  task automatic push_exp(int req, bit f, bit k, int idx, bit conf, logic [AW-1:0] tgt);
    exp_fail_q.push_back(m_pois(f, idx) || (k && conf));
    exp_addr_q.push_back(tgt);
    exp_req_q.push_back(req);
  endtask

  task automatic do_check(int req, bit f, bit k, int idx, bit conf, logic [AW-1:0] tgt);
    @(negedge clk);
    chk_file = f; chk_kind = k; chk_idx = idx[IW-1:0]; chk_conflict = conf; chk_target = tgt;
    chk_valid = 1'b1;
    #1;
    while (!chk_ready) begin @(negedge clk); #1; end
    push_exp(req, f, k, idx, conf, tgt);
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  // monitor: pops expectations as results appear (R9, R10)
  bit held = 1'b0;
  bit last_fail = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n === 1'b1 && !done) begin
        if (res_valid && !held) begin
          if (exp_fail_q.size() == 0) cmp("R9 unexpected result", 64'h1, 64'h0);
          else cmp($sformatf("R%0d rec_pulse", exp_req_q[0]), {63'h0, rec_pulse}, {63'h0, exp_fail_q[0]});
        end else if (res_valid) begin
          cmp("R10 pulse while held", {63'h0, rec_pulse}, 64'h0);
          cmp("R10 held result stable", {63'h0, res_fail}, {63'h0, last_fail});
        end
        if (res_valid && res_ready && exp_fail_q.size() != 0) begin
          cmp($sformatf("R%0d res_fail", exp_req_q[0]), {63'h0, res_fail}, {63'h0, exp_fail_q[0]});
          if (exp_fail_q[0]) cmp("R9 rec_addr", {16'h0, rec_addr}, {16'h0, exp_addr_q[0]});
          void'(exp_fail_q.pop_front());
          void'(exp_addr_q.pop_front());
          void'(exp_req_q.pop_front());
        end
        last_fail = res_fail;
        held = res_valid && !res_ready;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin
      int_dat_m[r] = '0; int_tag_m[r] = 1'b0; fp_dat_m[r] = '0;
    end
    rst_n = 1'b0; wr_valid = 0; wr_file = 0; wr_op = 0; wr_idx = 0; wr_src_a = 0;
    wr_src_b = 0; wr_fault = 0; wr_data = 0; rd_file = 0; rd_idx = 0;
    chk_valid = 0; chk_file = 0; chk_kind = 0; chk_idx = 0; chk_conflict = 0;
    chk_target = 0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    cmp("R1 res_valid", {63'h0, res_valid}, 64'h0);
    cmp("R1 rec_pulse", {63'h0, rec_pulse}, 64'h0);
    cmp("R1 chk_ready", {63'h0, chk_ready}, 64'h1);
    cmp("R1 wr_ready", {63'h0, wr_ready}, 64'h1);
    rdchk("R1 int reg", 0, 0, 5);
    rdchk("R1 fp reg", 1, 1, 9);

    // R2 plain writes
    wr(0, 0, 5, 0, 0, 0, 64'hA5A5_0000_1234_5678);
    rdchk("R2 int plain", 0, 0, 5);
    wr(1, 0, 9, 0, 0, 0, 64'h4009_21FB_5444_2D18);
    rdchk("R2 fp plain", 0, 1, 9);

    // R3 speculative loads
    wr(0, 1, 6, 0, 0, 1, 64'hDEAD_0000_0000_0006);
    rdchk("R3 int fault", 0, 0, 6);
    wr(0, 1, 8, 0, 0, 0, 64'h0000_0000_0000_0808);
    rdchk("R3 int no fault", 0, 0, 8);
    wr(1, 1, 10, 0, 0, 1, 64'h1111_2222_3333_4444);
    rdchk("R3 fp fault marker", 0, 1, 10);

    // R2 plain write clears tag, then re-poison
    wr(0, 0, 6, 0, 0, 0, 64'h0000_0000_0000_0E0E);
    rdchk("R2 tag cleared", 0, 0, 6);
    wr(0, 1, 6, 0, 0, 1, 64'h0);

    // R4 propagation
    wr(0, 2, 11, 6, 5, 0, 64'hF00D);
    rdchk("R4 int poisoned src", 0, 0, 11);
    wr(0, 2, 12, 5, 8, 0, 64'hBEEF);
    rdchk("R4 int clean srcs", 0, 0, 12);
    wr(1, 2, 11, 9, 10, 0, 64'h3FF0_0000_0000_0000);
    rdchk("R4 fp poisoned src", 0, 1, 11);
    wr(1, 2, 12, 9, 9, 0, 64'h4000_0000_0000_0000);
    rdchk("R4 fp clean srcs", 0, 1, 12);

    // R5 combined speculative load
    wr(0, 3, 13, 0, 0, 1, 64'h77);
    rdchk("R5 int combined fault", 0, 0, 13);
    wr(1, 3, 13, 0, 0, 0, 64'h4010_0000_0000_0000);
    rdchk("R5 fp combined clean", 0, 1, 13);

    // R6 register zero
    wr(0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rdchk("R6 int r0 plain", 0, 0, 0);
    wr(0, 1, 0, 0, 0, 1, 64'h1);
    rdchk("R6 int r0 fault", 1, 0, 0);
    wr(1, 1, 0, 0, 0, 1, 64'h1);
    rdchk("R6 fp r0 fault", 0, 1, 0);
    wr(0, 2, 14, 0, 5, 0, 64'h1414);
    rdchk("R6 r0 clean source", 1, 0, 14);
    rdchk("R4 port1 tag", 1, 0, 11);

    // R7 tag checks
    do_check(7, 0, 0, 6, 0, 48'h0000_1000_0040); // R7 fail
    do_check(7, 0, 0, 5, 0, 48'h0000_1000_0080); // R7 pass
    do_check(7, 1, 0, 10, 0, 48'h0000_2000_0000); // R7 fp fail
    do_check(7, 1, 0, 9, 0, 48'h0000_2000_0100); // R7 fp pass
    do_check(7, 0, 0, 5, 1, 48'h0000_2000_0200); // R7 conflict ignored

    // R8 advanced checks
    do_check(8, 0, 1, 13, 0, 48'h0000_3000_0000); // R8 poisoned
    do_check(8, 0, 1, 5, 1, 48'h0000_3000_0010); // R8 conflict
    do_check(8, 0, 1, 5, 0, 48'h0000_3000_0020); // R8 clean

    // R10 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    do_check(10, 0, 0, 11, 0, 48'h0000_4000_0000);
    chk_file = 0; chk_kind = 0; chk_idx = 5; chk_conflict = 0; chk_target = 48'h0000_4000_0004;
    chk_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      cmp("R10 chk_ready low", {63'h0, chk_ready}, 64'h0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    #1;
    cmp("R10 chk_ready high", {63'h0, chk_ready}, 64'h1);
    push_exp(10, 0, 0, 5, 0, 48'h0000_4000_0004);
    @(negedge clk);
    chk_valid = 1'b0;

    // R11 check with same-cycle write: sees old (clean) state of int r7
    @(negedge clk);
    chk_file = 0; chk_kind = 0; chk_idx = 7; chk_conflict = 0; chk_target = 48'h0000_5000_0000;
    chk_valid = 1'b1;
    push_exp(11, 0, 0, 7, 0, 48'h0000_5000_0000);
    wr_file = 0; wr_op = 2'd1; wr_idx = 7; wr_src_a = 0; wr_src_b = 0; wr_fault = 1; wr_data = 0;
    wr_valid = 1'b1;
    m_write(0, 1, 7, 0, 0, 1, 64'h0);
    @(negedge clk);
    chk_valid = 1'b0; wr_valid = 1'b0;
    do_check(11, 0, 0, 7, 0, 48'h0000_5000_0008); // R11 now fails

    repeat (4) @(negedge clk);
    cmp("R9 all results seen", exp_fail_q.size(), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule